// File: doc/BRIEF.md
# Three-Stage Forwarding Integer Pipeline

This block is a compact integer pipeline that executes a program held in a small instruction store. Each 32-bit instruction is either an ALU operation on two registers or an ALU operation on one register and a sign-extended 13-bit constant. An instruction moves through three latches (fetch-to-decode, decode-to-execute, execute-to-writeback) and then writes a 32-entry register file. When a source register is the destination of an instruction still in flight, the pending result is bypassed into the operand path, so the pipeline never waits on a dependency.

A drain input, `stall`, stops fetch. The program counter holds and empty slots enter the pipe. Instructions already in the latches still finish. Three stalled clock edges leave the pipe empty, and the register file then holds the same state that a one-instruction-at-a-time interpreter would reach after the same number of fetched instructions. The register file is read through a port for architectural inspection. The instruction store is filled through a simple write port.

Top module: `fp3_pipe`

## Requirements
- R1: While reset is active and after it is released, `pc_o` is 0, every register reads 0, and `retire_o` is low until an instruction has been fetched.
- R2: Instruction word fields are: bit 31 is the form flag (0 means register-register), bits 30:28 are the function, 27:23 rd, 22:18 ra and 17:13 rb. For the register form, rd receives ra OP rb. The function codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left by rb[4:0], 6 logical shift right by rb[4:0], and 7 signed less-than, which gives 1 or 0.
- R3: When bit 31 is 1 (immediate form), the second operand is bits 12:0 sign-extended to 32 bits, the rb field is ignored, and the function codes of R2 apply unchanged.
- R4: Every rising edge with `stall` low fetches one instruction and adds 4 to `pc_o`. The word fetched is the store entry at index `pc_o[IMEM_AW+1:2]`, so fetch wraps around the store.
- R5: Register 0 always reads 0. A write to it has no effect, and it is never bypassed as a pending result.
- R6: An instruction that reads a register written by one of the two instructions just before it gets the new value, with no lost cycles. The final register state matches sequential execution.
- R7: When the instructions in both the execute and the writeback stage write the needed register, the operand comes from the younger one, which is the one in execute.
- R8: A rising edge with `stall` high fetches nothing and leaves `pc_o` unchanged. Instructions already in flight still complete. After three consecutive stalled edges, `retire_o` is low and the registers stay constant.
- R9: An instruction fetched at edge k raises `retire_o` for exactly the cycle between edges k+2 and k+3, and its result is visible in the register file after edge k+3. The count of `retire_o` pulses equals the number of unstalled fetch edges.
- R10: Empty slots created by stalled fetches never change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Drain control: high blocks fetch |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IMEM_AW | Instruction store word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| arch_raddr | input | 5 | Register index for inspection |
| arch_rdata | output | 32 | Content of the inspected register |
| pc_o | output | 32 | Current fetch address |
| retire_o | output | 1 | High while a valid instruction writes back |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a bypass from the execute stage and a bypass from the writeback stage on the same register. This is provoked by two consecutive writes to one register followed at once by a reader, and it is judged by whether the reader saw the younger value. The second pair is a drain beginning while dependent instructions are still in the latches. This is provoked by stall patterns that toggle during dependency chains and across a wrap of the instruction store. It is judged by comparing every register and the retirement count against a sequential interpreter that runs exactly the number of unstalled fetches.

// File: rtl/fp3_pkg.sv
package fp3_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int NREG = 1 << RIDX;
    localparam int IMMW = 13;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4,
        FN_SHL = 3'd5,
        FN_SHR = 3'd6,
        FN_SLT = 3'd7
    } alu_fn_e;

    typedef struct packed {
        logic            imm_form;
        alu_fn_e         fn;
        ridx_t           rd;
        ridx_t           ra;
        ridx_t           rb;
        logic [IMMW-1:0] imm;
    } insn_t;

    typedef struct packed {
        logic  vld;
        insn_t insn;
    } fd_t;

    typedef struct packed {
        logic    vld;
        alu_fn_e fn;
        ridx_t   rd;
        word_t   opa;
        word_t   opb;
    } de_t;

    typedef struct packed {
        logic  vld;
        ridx_t rd;
        word_t res;
    } ew_t;
endpackage

// File: rtl/fp3_alu.sv
module fp3_alu
    import fp3_pkg::*;
(
    input  alu_fn_e fn,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        unique case (fn)
            FN_ADD: y = a + b;
            FN_SUB: y = a - b;
            FN_AND: y = a & b;
            FN_OR:  y = a | b;
            FN_XOR: y = a ^ b;
            FN_SHL: y = a << b[4:0];
            FN_SHR: y = a >> b[4:0];
            FN_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/fp3_regfile.sv
module fp3_regfile
    import fp3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ridx_t wa,
    input  word_t wd,
    input  ridx_t ra0,
    output word_t rd0,
    input  ridx_t ra1,
    output word_t rd1,
    input  ridx_t ra2,
    output word_t rd2
);
    logic [NREG-1:0][XLEN-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we && (wa != '0)) mem_d[wa] = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd0 = mem_q[ra0];
    assign rd1 = mem_q[ra1];
    assign rd2 = mem_q[ra2];
endmodule

// File: rtl/fp3_imem.sv
module fp3_imem
    import fp3_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fp3_pipe.sv
module fp3_pipe
    import fp3_pkg::*;
#(
    parameter int IMEM_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_waddr,
    input  logic [XLEN-1:0]    imem_wdata,
    input  logic [RIDX-1:0]    arch_raddr,
    output logic [XLEN-1:0]    arch_rdata,
    output logic [XLEN-1:0]    pc_o,
    output logic               retire_o
);
    typedef struct packed {
        word_t pc;
        fd_t   fd;
        de_t   de;
        ew_t   ew;
    } pipe_t;

    pipe_t st_d, st_q;
    word_t fetch_word;
    word_t rf_a, rf_b;
    word_t ex_res;
    insn_t dec;

    fp3_imem #(.AW(IMEM_AW)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (st_q.pc[IMEM_AW+1:2]),
        .rdata (fetch_word)
    );

    fp3_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_q.ew.vld),
        .wa    (st_q.ew.rd),
        .wd    (st_q.ew.res),
        .ra0   (dec.ra),
        .rd0   (rf_a),
        .ra1   (dec.rb),
        .rd1   (rf_b),
        .ra2   (arch_raddr),
        .rd2   (arch_rdata)
    );

    fp3_alu u_alu (
        .fn (st_q.de.fn),
        .a  (st_q.de.opa),
        .b  (st_q.de.opb),
        .y  (ex_res)
    );

    // Operand bypass: the execute-stage result wins over the writeback one.
    function automatic word_t bypass(ridx_t src, word_t rf_val, de_t de,
                                     word_t de_res, ew_t ew);
        if ((src != '0) && de.vld && (de.rd == src)) return de_res;
        if ((src != '0) && ew.vld && (ew.rd == src)) return ew.res;
        return rf_val;
    endfunction

    assign dec = st_q.fd.insn;

    always_comb begin
        st_d = st_q;
        // fetch
        st_d.fd.vld  = !stall;
        st_d.fd.insn = insn_t'(fetch_word);
        if (!stall) st_d.pc = st_q.pc + 32'd4;
        // decode with bypass
        st_d.de.vld = st_q.fd.vld;
        st_d.de.fn  = dec.fn;
        st_d.de.rd  = dec.rd;
        st_d.de.opa = bypass(dec.ra, rf_a, st_q.de, ex_res, st_q.ew);
        if (dec.imm_form)
            st_d.de.opb = {{(XLEN-IMMW){dec.imm[IMMW-1]}}, dec.imm};
        else
            st_d.de.opb = bypass(dec.rb, rf_b, st_q.de, ex_res, st_q.ew);
        // execute
        st_d.ew.vld = st_q.de.vld;
        st_d.ew.rd  = st_q.de.rd;
        st_d.ew.res = ex_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o     = st_q.pc;
    assign retire_o = st_q.ew.vld;
endmodule

// File: rtl/fp3_pipe_chk.sv
module fp3_pipe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stall,
    input logic [4:0]  arch_raddr,
    input logic [31:0] arch_rdata,
    input logic [31:0] pc_o,
    input logic        retire_o
);
    logic [1:0] stall_run_d, stall_run_q;

    always_comb begin
        stall_run_d = stall_run_q;
        if (!stall)                    stall_run_d = 2'd0;
        else if (stall_run_q != 2'd3)  stall_run_d = stall_run_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stall_run_q <= 2'd0;
        else        stall_run_q <= stall_run_d;
    end

    a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> pc_o == $past(pc_o) + 32'd4);

    a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc_o));

    a_r8_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_run_q == 2'd3) |-> !retire_o);

    a_r9_retire_src: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |-> !$past(stall, 3));

    a_r5_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (arch_raddr == 5'd0) |-> (arch_rdata == 32'd0));
endmodule

bind fp3_pipe fp3_pipe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .arch_raddr (arch_raddr),
    .arch_rdata (arch_rdata),
    .pc_o       (pc_o),
    .retire_o   (retire_o)
);

// File: tb/fp3_pipe_tb.sv
module fp3_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b1;
    logic          imem_we = 1'b0;
    logic [AW-1:0] imem_waddr = '0;
    logic [31:0]   imem_wdata = '0;
    logic [4:0]    arch_raddr = '0;
    logic [31:0]   arch_rdata;
    logic [31:0]   pc_o;
    logic          retire_o;

    int total = 0;
    int bad = 0;
    int nf = 0;
    int rcnt = 0;
    logic [31:0] prog [DEPTH];
    logic [31:0] refr [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp3_pipe #(.IMEM_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .arch_raddr(arch_raddr), .arch_rdata(arch_rdata),
        .pc_o(pc_o), .retire_o(retire_o)
    );

    always @(negedge clk) begin
        if (!rst_n) rcnt <= 0;
        else if (retire_o) rcnt <= rcnt + 1;
    end

    function automatic logic [31:0] enc_r(int fn, int rd, int ra, int rb);
        return {1'b0, fn[2:0], rd[4:0], ra[4:0], rb[4:0], 13'd0};
    endfunction

    function automatic logic [31:0] enc_i(int fn, int rd, int ra, int imm);
        return {1'b1, fn[2:0], rd[4:0], ra[4:0], 5'd0, imm[12:0]};
    endfunction

    function automatic logic [31:0] ref_alu(int fn, logic [31:0] a, logic [31:0] b);
        case (fn)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << b[4:0];
            6: return a >> b[4:0];
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic ref_run();
        for (int r = 0; r < 32; r++) refr[r] = '0;
        for (int i = 0; i < nf; i++) begin
            logic [31:0] w;
            logic [31:0] b;
            w = prog[i % DEPTH];
            b = w[31] ? {{19{w[12]}}, w[12:0]} : refr[w[17:13]];
            if (w[27:23] != 5'd0)
                refr[w[27:23]] = ref_alu(int'(w[30:28]), refr[w[22:18]], b);
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp_regs(input string req);
        ref_run();
        for (int r = 0; r < 32; r++) begin
            arch_raddr = 5'(r);
            #1;
            chk(req, arch_rdata, refr[r]);
        end
    endtask

    task automatic nop_fill();
        for (int i = 0; i < DEPTH; i++) prog[i] = enc_i(0, 0, 0, 0);
    endtask

    task automatic boot();
        rst_n = 1'b0;
        stall = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            imem_we = 1'b1;
            imem_waddr = AW'(i);
            imem_wdata = prog[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        nf = 0;
    endtask

    task automatic run(input int n);
        stall = 1'b0;
        repeat (n) @(negedge clk);
        stall = 1'b1;
        nf += n;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic t_reset_bubbles();
        nop_fill();
        prog[0] = enc_i(0, 1, 0, 7);
        prog[1] = enc_i(0, 2, 0, 9);
        boot();
        #1;
        chk("R1 pc after reset", pc_o, 32'd0);
        chk("R1 retire after reset", {31'd0, retire_o}, 32'd0);
        cmp_regs("R1 regs after reset");
        repeat (6) @(negedge clk);
        #1;
        chk("R10 no retire from bubbles", rcnt, 32'd0);
        chk("R8 pc held while stalled", pc_o, 32'd0);
        cmp_regs("R10 regs untouched by bubbles");
    endtask

    task automatic t_latency();
        nop_fill();
        prog[0] = enc_i(0, 5, 0, 11);
        boot();
        run(1);
        #1;
        chk("R9 retire low after fetch edge", {31'd0, retire_o}, 32'd0);
        chk("R4 pc after one fetch", pc_o, 32'd4);
        @(negedge clk); #1;
        chk("R9 retire low one edge later", {31'd0, retire_o}, 32'd0);
        @(negedge clk); #1;
        chk("R9 retire high two edges later", {31'd0, retire_o}, 32'd1);
        arch_raddr = 5'd5; #1;
        chk("R9 reg not yet written", arch_rdata, 32'd0);
        @(negedge clk); #1;
        chk("R9 retire low three edges later", {31'd0, retire_o}, 32'd0);
        arch_raddr = 5'd5; #1;
        chk("R9 reg written after third edge", arch_rdata, 32'd11);
    endtask

    task automatic t_imm();
        nop_fill();
        prog[0]  = enc_i(0, 1, 0, 5);
        prog[1]  = enc_i(0, 2, 0, -3);
        prog[2]  = enc_i(2, 3, 2, 13'h0F0);
        prog[3]  = enc_i(3, 4, 0, 13'h123);
        prog[4]  = enc_i(4, 5, 2, -1);
        prog[5]  = enc_i(5, 6, 1, 4);
        prog[6]  = enc_i(6, 7, 2, 28);
        prog[7]  = enc_i(7, 8, 2, 0);
        prog[8]  = enc_i(7, 9, 1, -1);
        prog[9]  = enc_i(0, 10, 0, 4095);
        prog[10] = enc_i(0, 11, 0, -4096);
        prog[11] = enc_i(1, 12, 11, 1) | 32'h0003_E000;
        boot();
        run(12);
        drain();
        cmp_regs("R3 immediate forms");
    endtask

    task automatic t_rr();
        nop_fill();
        prog[0]  = enc_i(0, 1, 0, -8);
        prog[1]  = enc_i(0, 2, 0, 3);
        prog[2]  = enc_i(0, 9, 0, 0);
        prog[3]  = enc_r(0, 3, 1, 2);
        prog[4]  = enc_r(1, 4, 2, 1);
        prog[5]  = enc_r(2, 5, 1, 2);
        prog[6]  = enc_r(3, 6, 1, 2);
        prog[7]  = enc_r(4, 7, 1, 2);
        prog[8]  = enc_r(5, 8, 2, 2);
        prog[9]  = enc_r(6, 9, 1, 2);
        prog[10] = enc_r(7, 10, 1, 2);
        prog[11] = enc_r(7, 11, 2, 1);
        boot();
        run(12);
        drain();
        cmp_regs("R2 register forms");
    endtask

    task automatic t_fwd();
        nop_fill();
        prog[0] = enc_i(0, 1, 0, 7);
        prog[1] = enc_r(0, 2, 1, 1);
        prog[2] = enc_r(0, 3, 2, 1);
        prog[3] = enc_r(1, 4, 3, 2);
        prog[4] = enc_r(5, 5, 4, 1);
        prog[5] = enc_r(4, 6, 5, 4);
        prog[6] = enc_i(6, 7, 6, 2);
        prog[7] = enc_r(0, 8, 7, 6);
        boot();
        run(8);
        drain();
        cmp_regs("R6 back to back bypass");
    endtask

    task automatic t_prio();
        nop_fill();
        prog[0] = enc_i(0, 1, 0, 1);
        prog[1] = enc_i(0, 1, 0, 2);
        prog[2] = enc_r(0, 2, 1, 1);
        prog[3] = enc_i(0, 3, 0, 5);
        prog[4] = enc_i(0, 3, 3, 1);
        prog[5] = enc_r(1, 4, 3, 1);
        boot();
        run(6);
        drain();
        arch_raddr = 5'd2; #1;
        chk("R7 younger result chosen", arch_rdata, 32'd4);
        cmp_regs("R7 priority program");
    endtask

    task automatic t_zero();
        nop_fill();
        prog[0] = enc_i(0, 0, 0, 9);
        prog[1] = enc_r(0, 1, 0, 0);
        prog[2] = enc_i(0, 2, 0, 3);
        prog[3] = enc_r(0, 0, 2, 2);
        prog[4] = enc_r(0, 3, 0, 2);
        boot();
        run(5);
        drain();
        arch_raddr = 5'd0; #1;
        chk("R5 r0 stays zero", arch_rdata, 32'd0);
        arch_raddr = 5'd3; #1;
        chk("R5 r0 not bypassed", arch_rdata, 32'd3);
        cmp_regs("R5 zero register program");
    endtask

    task automatic t_drain();
        nop_fill();
        prog[0] = enc_i(0, 1, 0, 2);
        prog[1] = enc_r(0, 2, 1, 1);
        prog[2] = enc_r(5, 3, 2, 1);
        prog[3] = enc_r(1, 4, 3, 2);
        prog[4] = enc_r(0, 5, 4, 3);
        prog[5] = enc_r(4, 6, 5, 1);
        prog[6] = enc_i(3, 7, 6, 1);
        prog[7] = enc_r(7, 8, 1, 7);
        boot();
        run(3);
        drain();
        chk("R8 pc held during drain", pc_o, 32'd12);
        chk("R8 in-flight work retired", rcnt, 32'd3);
        cmp_regs("R8 state after drain");
        repeat (3) @(negedge clk);
        #1;
        chk("R8 no further retire", rcnt, 32'd3);
        run(5);
        drain();
        chk("R9 retire count equals fetches", rcnt, 32'd8);
        cmp_regs("R8 state after resume");
    endtask

    task automatic t_toggle_wrap();
        int fetched;
        nop_fill();
        prog[0]  = enc_i(0, 1, 1, 3);
        prog[1]  = enc_r(0, 2, 1, 2);
        prog[2]  = enc_r(4, 3, 2, 1);
        prog[3]  = enc_i(5, 4, 3, 1);
        prog[4]  = enc_r(1, 5, 4, 2);
        prog[5]  = enc_r(3, 6, 5, 3);
        prog[6]  = enc_r(7, 7, 6, 5);
        prog[7]  = enc_r(0, 8, 7, 1);
        prog[8]  = enc_i(6, 9, 2, 1);
        prog[9]  = enc_r(0, 1, 9, 8);
        prog[10] = enc_r(1, 2, 1, 9);
        prog[11] = enc_r(2, 3, 2, 1);
        prog[12] = enc_i(0, 4, 4, -7);
        prog[13] = enc_r(0, 5, 4, 3);
        prog[14] = enc_r(4, 6, 5, 4);
        prog[15] = enc_r(0, 7, 7, 6);
        boot();
        fetched = 0;
        for (int i = 0; i < 30; i++) begin
            stall = ((i % 3) == 1);
            if (!stall) fetched++;
            @(negedge clk);
        end
        stall = 1'b1;
        nf = fetched;
        drain();
        chk("R4 pc after toggled stall and wrap", pc_o, 32'(4 * fetched));
        chk("R9 retire count with toggled stall", rcnt, 32'(fetched));
        cmp_regs("R4 wrapped toggled program");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_bubbles();
        t_latency();
        t_imm();
        t_rr();
        t_fwd();
        t_prio();
        t_zero();
        t_drain();
        t_toggle_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule